// File: doc/BRIEF.md
# Logarithmic Multiplexer Barrel Shifter

This block shifts or rotates a 32-bit word by any distance from 0 to 31 in a single combinational pass. It has no clock. The data, the distance and a 2-bit operation code go in, and the result comes out in the same cycle. A datapath can therefore place it directly between operand registers and a result register.

The core is a stack of binary-weighted multiplexer columns. The column for distance bit k moves every bit 2^k places toward the low end, or passes the word through unchanged. Bits leaving the low end are replaced in one of two ways:

- a fill value chosen by the operation: zero, or the sign bit;
- or, for rotate, the bits that fell off the low end, routed back in at the top.

Left shifts use the same right-moving columns. The word is mirrored before the columns and mirrored again after them.

Top module: `log_barrel_shifter`

## Requirements
- R1: With `op` = 2'b00 (logical left), `dout` equals `din` moved toward the MSB by `amt` places, with the `amt` lowest bits 0.
- R2: With `op` = 2'b01 (logical right), `dout` equals `din` moved toward the LSB by `amt` places, with the `amt` highest bits 0.
- R3: With `op` = 2'b10 (arithmetic right), `dout` equals `din` moved toward the LSB by `amt` places, with the `amt` highest bits equal to `din[31]`.
- R4: With `op` = 2'b11 (rotate right), `dout[i]` equals `din[(i+amt) mod 32]` for every bit i.
- R5: When `amt` is 0, `dout` equals `din` for all four operations.
- R6: Every distance in the full range 0 to 31 is honoured. At 31, a logical right shift leaves only the old bit 31 in bit 0, and a logical left shift leaves only the old bit 0 in bit 31.
- R7: Each bit k of `amt` contributes a movement of exactly 2^k, so single-bit distances 1, 2, 4, 8 and 16 each give the exact shifted result.
- R8: A rotate keeps the number of 1 bits in the word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Word to shift or rotate |
| amt | input | 5 | Distance in bit places, 0 to 31 |
| op | input | 2 | Operation: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| dout | output | 32 | Result |

## Verification
The assertions assume that `din`, `amt` and `op` are settled, known values whenever the combinational checker evaluates. They also assume that every 2-bit `op` code is meaningful, so no code is treated as illegal.

The stimulus meets these assumptions. It changes all inputs together on one clock edge and reads the result on the opposite edge, and it never drives X or Z. Across each operation, the stimulus covers every distance with these data words:
- all zeros and all ones;
- a lone MSB and a lone LSB;
- alternating bits;
- a largest positive value;
- a set of random words.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    SH_SLL = 2'b00,
    SH_SRL = 2'b01,
    SH_SRA = 2'b10,
    SH_ROR = 2'b11
  } shift_op_e;

  // Value entering vacated high positions of the right-moving network.
  function automatic logic fill_for(shift_op_e o, logic msb);
    return (o == SH_SRA) ? msb : 1'b0;
  endfunction

  // Left shifts are done by mirroring around the right-moving network.
  function automatic logic mirror_for(shift_op_e o);
    return (o == SH_SLL);
  endfunction

  // Rotate routes bits leaving the low end back to the high end.
  function automatic logic wrap_for(shift_op_e o);
    return (o == SH_ROR);
  endfunction

endpackage

// File: rtl/bshift_mirror.sv
module bshift_mirror #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = en ? din[W-1-i] : din[i];
  end
endmodule

// File: rtl/bshift_rank.sv
module bshift_rank #(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic         sel,
  input  logic         wrap,
  input  logic         fill,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] moved;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i + DIST < W) begin : g_inner
      assign moved[i] = din[i+DIST];
    end else begin : g_edge
      assign moved[i] = wrap ? din[i+DIST-W] : fill;
    end
    assign dout[i] = sel ? moved[i] : din[i];
  end
endmodule

// File: rtl/log_barrel_shifter.sv
module log_barrel_shifter #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic [1:0]    op,
  output logic [W-1:0]  dout
);
  import bshift_pkg::*;

  shift_op_e op_e;
  logic      fill_bit;
  logic      wrap_en;
  logic      mirror_en;

  logic [AW:0][W-1:0] stage;

  assign op_e      = shift_op_e'(op);
  assign fill_bit  = fill_for(op_e, din[W-1]);
  assign wrap_en   = wrap_for(op_e);
  assign mirror_en = mirror_for(op_e);

  bshift_mirror #(.W(W)) u_pre (
    .en   (mirror_en),
    .din  (din),
    .dout (stage[0])
  );

  for (genvar k = 0; k < AW; k++) begin : g_rank
    bshift_rank #(.W(W), .DIST(1 << k)) u_rank (
      .sel  (amt[k]),
      .wrap (wrap_en),
      .fill (fill_bit),
      .din  (stage[k]),
      .dout (stage[k+1])
    );
  end

  bshift_mirror #(.W(W)) u_post (
    .en   (mirror_en),
    .din  (stage[AW]),
    .dout (dout)
  );
endmodule

// File: rtl/log_barrel_shifter_chk.sv
module log_barrel_shifter_chk #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input logic [W-1:0]  din,
  input logic [AW-1:0] amt,
  input logic [1:0]    op,
  input logic [W-1:0]  dout
);
  logic [W-1:0] low_mask;
  logic [W-1:0] high_mask;

  always_comb begin
    low_mask  = ~({W{1'b1}} << amt);
    high_mask = ~({W{1'b1}} >> amt);

    a_r5_zero_identity: assert (amt != '0 || dout == din)
      else $error("R5 zero distance changed data");
    a_r1_left_low_zero: assert (op != 2'b00 || (dout & low_mask) == '0)
      else $error("R1 vacated low bits not zero");
    a_r2_right_high_zero: assert (op != 2'b01 || (dout & high_mask) == '0)
      else $error("R2 vacated high bits not zero");
    a_r3_arith_sign_fill: assert (op != 2'b10 ||
                                  (dout & high_mask) == (din[W-1] ? high_mask : '0))
      else $error("R3 vacated high bits not sign copies");
    a_r8_rotate_ones: assert (op != 2'b11 || $countones(dout) == $countones(din))
      else $error("R8 rotate changed population");
  end
endmodule

bind log_barrel_shifter log_barrel_shifter_chk #(.W(W), .AW(AW)) u_chk (
  .din  (din),
  .amt  (amt),
  .op   (op),
  .dout (dout)
);

// File: tb/tb_log_barrel_shifter.sv
module tb_log_barrel_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] din = '0;
  logic [4:0]  amt = '0;
  logic [1:0]  op = '0;
  logic [31:0] dout;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] d;
    logic [4:0]  a;
    logic [1:0]  o;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];

  always #10 clk = ~clk;

  log_barrel_shifter dut (.din(din), .amt(amt), .op(op), .dout(dout));

  function automatic logic [31:0] model(logic [31:0] d, logic [4:0] a, logic [1:0] o);
    logic [63:0] two;
    case (o)
      2'b00: return d << a;
      2'b01: return d >> a;
      2'b10: return $signed(d) >>> a;
      default: begin
        two = {d, d} >> a;
        return two[31:0];
      end
    endcase
  endfunction

  function automatic string tag_for(logic [4:0] a, logic [1:0] o);
    if (a == 0) return "R5";
    if (a == 31) return "R6";
    if (a == 1 || a == 2 || a == 4 || a == 8 || a == 16) return "R7";
    case (o)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic drive(logic [31:0] d, logic [4:0] a, logic [1:0] o);
    item_t it;
    @(posedge clk);
    din = d; amt = a; op = o;
    it.d = d; it.a = a; it.o = o;
    it.exp = model(d, a, o);
    it.tag = tag_for(a, o);
    sbq.push_back(it);
  endtask

  // Monitor: compare half a cycle after the inputs were applied.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (dout !== it.exp) begin
        errors++;
        $display("FAIL %s op=%0d amt=%0d din=%h actual=%h expected=%h",
                 it.tag, it.o, it.a, it.d, dout, it.exp);
      end
      if (it.o == 2'b11) begin
        checks++;
        if ($countones(dout) != $countones(it.d)) begin
          errors++;
          $display("FAIL R8 ones actual=%0d expected=%0d",
                   $countones(dout), $countones(it.d));
        end
      end
    end
  end

  initial begin
    logic [31:0] pats [14];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
    pats[4] = 32'hAAAA_AAAA; pats[5] = 32'h7FFF_FFFF;
    for (int r = 6; r < 14; r++) pats[r] = $urandom;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Quiescent state: zero in, zero out (R5).
    drive(32'h0, 5'd0, 2'b00);
    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 14; p++)
        for (int a = 0; a < 32; a++)
          drive(pats[p], 5'(a), 2'(o));
    // Explicit boundary words for R6.
    drive(32'h8000_0000, 5'd31, 2'b01);
    drive(32'h0000_0001, 5'd31, 2'b00);
    @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule